// File: doc/BRIEF.md
# IDE Channel Register Decoder

This block is the memory-mapped front end of a single IDE channel. It sits on a simple little-endian register bus with a 4 KiB window. Each access carries an address, write data, a read or write strobe and a byte count of 1, 2 or 4. The upper address bits pick a register slot, and slots are 16 bytes apart. Data-port, taskfile, status and device-control accesses become single-cycle strobes on a drive-side port. A timing register and an interrupt-state register are held inside the block.

Each slot answers only the access sizes listed for it. Any other access is dropped. A dropped read returns all ones. The interrupt-state register tracks the DMA and disk interrupt lines as they change level. Software can clear the DMA bit by writing a one to it. Both lines also pass straight through to their own outputs.

Top module: `ide_chan_regs`

## Requirements
- R1: The slot index is `bus_addr[11:4]`. Address bits 3:0 have no effect on decode. Each access drives at most one of the six drive-side strobes.
- R2: `bus_size` is the access width in bytes, and only the values 1, 2 and 4 are valid. A read returns 32'hFFFFFFFF when its slot is not listed below, when it uses an invalid size, or when it uses a size the slot refuses. No drive-side strobe fires for such an access.
- R3: A read of slot 0x00 drives `dp_rd` high for exactly one cycle per access. At size 4 it sets `dp_wide`=1 and returns all 32 bits of `dp_rdata`. At size 2 it sets `dp_wide`=0 and returns bits 15:0, zero-extended. At size 1 it sets `dp_wide`=0 and returns bits 7:0, zero-extended.
- R4: A write to slot 0x00 at size 2 or 4 pulses `dp_wr` with `dp_wdata`=`bus_wdata`, and `dp_wide`=1 only at size 4. A 1-byte write to this slot is dropped.
- R5: Slots 0x01 to 0x07 respond only to 1-byte accesses. They drive `tf_idx` = slot bits 2:0. A read returns `tf_rdata` zero-extended. A write pulses `tf_wr` with `tf_wdata`=`bus_wdata[7:0]`.
- R6: Slots 0x08 and 0x16 behave the same way, and only at size 1. A read pulses `st_rd` and returns `st_rdata` zero-extended. A write pulses `ctl_wr` with `ctl_wdata`=`bus_wdata[7:0]`.
- R7: Slot 0x20 is a 32-bit timing register, read and written only at size 4. It has no effect elsewhere.
- R8: Slot 0x30, read at size 4, returns the interrupt state. Bit 31 is the DMA line and bit 30 is the disk line, and every other bit is 0. A bit takes the new level of its line on the clock edge where the change is first sampled.
- R9: A 4-byte write to slot 0x30 with bit 31 set clears bit 31 only, and all other written bits are ignored. If a DMA line change is sampled in the same cycle, the line level wins over the clear.
- R10: `irq_dma_out` follows `irq_dma_in` and `irq_disk_out` follows `irq_disk_in`, both combinationally.
- R11: Reset clears the timing register, the interrupt state and `bus_rdata` to zero. `drv_rst` is high while `rst_n` is low and stays high until the first clock edge after release.
- R12: Read data is registered. It appears in the cycle after the read strobe and holds until the next read.
- R13: When `bus_rd` and `bus_wr` are both high, the write is dropped and the read goes ahead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_size | input | 3 | Access width in bytes |
| bus_rdata | output | 32 | Registered read data |
| dp_rd | output | 1 | Data-port read strobe |
| dp_wr | output | 1 | Data-port write strobe |
| dp_wide | output | 1 | Data-port access is 32 bits |
| dp_wdata | output | 32 | Data-port write data |
| dp_rdata | input | 32 | Data-port read data |
| tf_rd | output | 1 | Taskfile read strobe |
| tf_wr | output | 1 | Taskfile write strobe |
| tf_idx | output | 3 | Taskfile register number |
| tf_wdata | output | 8 | Taskfile write data |
| tf_rdata | input | 8 | Taskfile read data |
| st_rd | output | 1 | Status read strobe |
| st_rdata | input | 8 | Status read data |
| ctl_wr | output | 1 | Device-control write strobe |
| ctl_wdata | output | 8 | Device-control write data |
| drv_rst | output | 1 | Reset pulse to the drive side |
| irq_dma_in | input | 1 | DMA interrupt line |
| irq_disk_in | input | 1 | Disk interrupt line |
| irq_dma_out | output | 1 | DMA interrupt passed through |
| irq_disk_out | output | 1 | Disk interrupt passed through |

## Verification
Two events can land in the same cycle: software clearing the DMA bit through slot 0x30, and the DMA line changing level. The bench issues the clearing write in the same cycle that it raises the DMA line. It then reads slot 0x30 and expects bit 31 to be set. It also issues a clear while the line stays high, and expects bit 31 to stay low until the line toggles again.

// File: rtl/ide_chan_pkg.sv
package ide_chan_pkg;

  localparam logic [7:0] SLOT_DATA   = 8'h00;
  localparam logic [7:0] SLOT_TF_LO  = 8'h01;
  localparam logic [7:0] SLOT_TF_HI  = 8'h07;
  localparam logic [7:0] SLOT_STAT_A = 8'h08;
  localparam logic [7:0] SLOT_STAT_B = 8'h16;
  localparam logic [7:0] SLOT_TIMING = 8'h20;
  localparam logic [7:0] SLOT_IRQ    = 8'h30;

  // interrupt line numbering: line n owns state bit (31 - n)
  localparam int LINE_DMA  = 0;
  localparam int LINE_DISK = 1;

  typedef struct packed {
    logic dp_rd;
    logic dp_wr;
    logic tf_rd;
    logic tf_wr;
    logic st_rd;
    logic ctl_wr;
    logic tm_rd;
    logic tm_wr;
    logic irq_rd;
    logic irq_wr;
  } strb_t;

  function automatic logic size_ok(input logic [2:0] sz);
    return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
  endfunction

  function automatic logic [31:0] dp_fold(input logic [2:0] sz, input logic [31:0] w);
    case (sz)
      3'd1:    return {24'h0, w[7:0]};
      3'd2:    return {16'h0, w[15:0]};
      default: return w;
    endcase
  endfunction

endpackage

// File: rtl/ide_slot_decode.sv
module ide_slot_decode
  import ide_chan_pkg::*;
#(
  parameter int SLOT_W = 8
) (
  input  logic [SLOT_W-1:0] slot,
  input  logic [2:0]        size,
  input  logic              rd,
  input  logic              wr,
  output strb_t             strb,
  output logic [2:0]        tf_idx
);

  logic wr_only;
  logic sz1, sz4, sz_any, sz_wide;
  logic is_data, is_tf, is_stat, is_tm, is_irq;

  assign wr_only = wr && !rd;
  assign sz1     = (size == 3'd1);
  assign sz4     = (size == 3'd4);
  assign sz_any  = size_ok(size);
  assign sz_wide = (size == 3'd2) || sz4;

  assign is_data = (slot == SLOT_DATA);
  assign is_tf   = (slot >= SLOT_TF_LO) && (slot <= SLOT_TF_HI);
  assign is_stat = (slot == SLOT_STAT_A) || (slot == SLOT_STAT_B);
  assign is_tm   = (slot == SLOT_TIMING);
  assign is_irq  = (slot == SLOT_IRQ);

  assign tf_idx = slot[2:0];

  always_comb begin
    strb        = '0;
    strb.dp_rd  = rd && is_data && sz_any;
    strb.dp_wr  = wr_only && is_data && sz_wide;
    strb.tf_rd  = rd && is_tf && sz1;
    strb.tf_wr  = wr_only && is_tf && sz1;
    strb.st_rd  = rd && is_stat && sz1;
    strb.ctl_wr = wr_only && is_stat && sz1;
    strb.tm_rd  = rd && is_tm && sz4;
    strb.tm_wr  = wr_only && is_tm && sz4;
    strb.irq_rd = rd && is_irq && sz4;
    strb.irq_wr = wr_only && is_irq && sz4;
  end

endmodule

// File: rtl/ide_irq_state.sv
module ide_irq_state #(
  parameter int N_LINES = 2,
  parameter int W       = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] lines,
  input  logic               clr_top,
  output logic [W-1:0]       state
);

  assign state[W-N_LINES-1:0] = '0;

  for (genvar n = 0; n < N_LINES; n++) begin : g_line
    logic seen_q;
    logic bit_q;
    logic changed;

    assign changed = (lines[n] != seen_q);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        seen_q <= 1'b0;
        bit_q  <= 1'b0;
      end else begin
        seen_q <= lines[n];
        if (changed)
          bit_q <= lines[n];
        else if ((n == 0) && clr_top)
          bit_q <= 1'b0;
      end
    end

    assign state[W-1-n] = bit_q;
  end

endmodule

// File: rtl/ide_chan_regs.sv
module ide_chan_regs
  import ide_chan_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int SLOT_SHIFT = 4,
  parameter int TM_W       = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [2:0]        bus_size,
  output logic [31:0]       bus_rdata,
  output logic              dp_rd,
  output logic              dp_wr,
  output logic              dp_wide,
  output logic [31:0]       dp_wdata,
  input  logic [31:0]       dp_rdata,
  output logic              tf_rd,
  output logic              tf_wr,
  output logic [2:0]        tf_idx,
  output logic [7:0]        tf_wdata,
  input  logic [7:0]        tf_rdata,
  output logic              st_rd,
  input  logic [7:0]        st_rdata,
  output logic              ctl_wr,
  output logic [7:0]        ctl_wdata,
  output logic              drv_rst,
  input  logic              irq_dma_in,
  input  logic              irq_disk_in,
  output logic              irq_dma_out,
  output logic              irq_disk_out
);

  localparam int SLOT_W  = ADDR_W - SLOT_SHIFT;
  localparam int N_LINES = 2;

  strb_t             strb;
  logic [SLOT_W-1:0] slot;
  logic              unused_addr_lo;
  logic [TM_W-1:0]   timing_q;
  logic [31:0]       irq_state;
  logic [31:0]       rd_next;
  logic [31:0]       rdata_q;
  logic              rst_pend_q;
  logic              tm_wr_evt;
  logic              irq_clr_evt;

  assign slot           = bus_addr[ADDR_W-1:SLOT_SHIFT];
  assign unused_addr_lo = ^bus_addr[SLOT_SHIFT-1:0];

  ide_slot_decode #(.SLOT_W(SLOT_W)) u_dec (
    .slot   (slot),
    .size   (bus_size),
    .rd     (bus_rd),
    .wr     (bus_wr),
    .strb   (strb),
    .tf_idx (tf_idx)
  );

  assign dp_rd     = strb.dp_rd;
  assign dp_wr     = strb.dp_wr;
  assign dp_wide   = (bus_size == 3'd4);
  assign dp_wdata  = bus_wdata;
  assign tf_rd     = strb.tf_rd;
  assign tf_wr     = strb.tf_wr;
  assign tf_wdata  = bus_wdata[7:0];
  assign st_rd     = strb.st_rd;
  assign ctl_wr    = strb.ctl_wr;
  assign ctl_wdata = bus_wdata[7:0];

  assign tm_wr_evt   = strb.tm_wr;
  assign irq_clr_evt = strb.irq_wr && bus_wdata[31];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      timing_q <= '0;
    else if (tm_wr_evt)
      timing_q <= bus_wdata[TM_W-1:0];
  end

  ide_irq_state #(.N_LINES(N_LINES), .W(32)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .lines   ({irq_disk_in, irq_dma_in}),
    .clr_top (irq_clr_evt),
    .state   (irq_state)
  );

  assign irq_dma_out  = irq_dma_in;
  assign irq_disk_out = irq_disk_in;

  always_comb begin
    rd_next = '1;
    if (strb.dp_rd)       rd_next = dp_fold(bus_size, dp_rdata);
    else if (strb.tf_rd)  rd_next = {24'h0, tf_rdata};
    else if (strb.st_rd)  rd_next = {24'h0, st_rdata};
    else if (strb.tm_rd)  rd_next = 32'(timing_q);
    else if (strb.irq_rd) rd_next = irq_state;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rdata_q <= '0;
    else if (bus_rd)
      rdata_q <= rd_next;
  end

  assign bus_rdata = rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_pend_q <= 1'b1;
    else
      rst_pend_q <= 1'b0;
  end

  assign drv_rst = rst_pend_q;

endmodule

// File: rtl/ide_chan_regs_chk.sv
module ide_chan_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_rd,
  input logic [2:0]  bus_size,
  input logic [31:0] bus_rdata,
  input logic        dp_rd,
  input logic        dp_wr,
  input logic        tf_rd,
  input logic        tf_wr,
  input logic        st_rd,
  input logic        ctl_wr,
  input logic        tm_wr_evt,
  input logic [31:0] timing_q,
  input logic        irq_dma_in,
  input logic        irq_disk_in,
  input logic [31:0] irq_state,
  input logic        drv_rst
);

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dp_rd, dp_wr, tf_rd, tf_wr, st_rd, ctl_wr})); // R1

  AST_BAD_SIZE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !(bus_size == 3'd1 || bus_size == 3'd2 || bus_size == 3'd4))
      |=> (bus_rdata == 32'hFFFF_FFFF)); // R2

  AST_TF_BYTE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (tf_rd || tf_wr) |-> (bus_size == 3'd1)); // R5

  AST_TIMING_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tm_wr_evt |=> $stable(timing_q)); // R7

  AST_DISK_FALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_disk_in) |=> !irq_state[30]); // R8

  AST_DMA_RISE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_dma_in) |=> irq_state[31]); // R9

  AST_DRV_RST_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    drv_rst |=> !drv_rst); // R11

endmodule

bind ide_chan_regs ide_chan_regs_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_rd      (bus_rd),
  .bus_size    (bus_size),
  .bus_rdata   (bus_rdata),
  .dp_rd       (dp_rd),
  .dp_wr       (dp_wr),
  .tf_rd       (tf_rd),
  .tf_wr       (tf_wr),
  .st_rd       (st_rd),
  .ctl_wr      (ctl_wr),
  .tm_wr_evt   (tm_wr_evt),
  .timing_q    (timing_q),
  .irq_dma_in  (irq_dma_in),
  .irq_disk_in (irq_disk_in),
  .irq_state   (irq_state),
  .drv_rst     (drv_rst)
);

// File: tb/ide_chan_regs_bench.sv
`timescale 1ns/1ps
module ide_chan_regs_bench;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_wr, bus_rd;
  logic [2:0]  bus_size;
  logic [31:0] bus_rdata;
  logic        dp_rd, dp_wr, dp_wide;
  logic [31:0] dp_wdata, dp_rdata;
  logic        tf_rd, tf_wr;
  logic [2:0]  tf_idx;
  logic [7:0]  tf_wdata, tf_rdata;
  logic        st_rd;
  logic [7:0]  st_rdata;
  logic        ctl_wr;
  logic [7:0]  ctl_wdata;
  logic        drv_rst;
  logic        irq_dma_in, irq_disk_in, irq_dma_out, irq_disk_out;

  int checks = 0;
  int errors = 0;

  logic [31:0] dp_val;
  logic [31:0] tm_sh;
  logic [31:0] irq_sh;

  assign dp_rdata = dp_val;
  assign tf_rdata = {5'b10101, tf_idx};
  assign st_rdata = 8'h5A;

  ide_chan_regs u_ide_chan_regs (.*);

  // capture of drive-side strobes at each edge
  logic [5:0]  cap_vec;
  logic        cap_wide;
  logic [2:0]  cap_idx;
  logic [31:0] cap_dpw;
  logic [7:0]  cap_tfw, cap_ctl;
  always @(posedge clk) begin
    cap_vec  <= {dp_rd, dp_wr, tf_rd, tf_wr, st_rd, ctl_wr};
    cap_wide <= dp_wide;
    cap_idx  <= tf_idx;
    cap_dpw  <= dp_wdata;
    cap_tfw  <= tf_wdata;
    cap_ctl  <= ctl_wdata;
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic sz_valid(input logic [2:0] sz);
    return sz == 3'd1 || sz == 3'd2 || sz == 3'd4;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [11:0] a, input logic [2:0] sz);
    logic [7:0] s;
    s = a[11:4];
    if (s == 8'h00) begin
      if (sz == 3'd1) return {24'h0, dp_val[7:0]};
      if (sz == 3'd2) return {16'h0, dp_val[15:0]};
      if (sz == 3'd4) return dp_val;
    end else if (s >= 8'h01 && s <= 8'h07) begin
      if (sz == 3'd1) return {24'h0, 5'b10101, s[2:0]};
    end else if (s == 8'h08 || s == 8'h16) begin
      if (sz == 3'd1) return 32'h5A;
    end else if (s == 8'h20) begin
      if (sz == 3'd4) return tm_sh;
    end else if (s == 8'h30) begin
      if (sz == 3'd4) return irq_sh;
    end
    return 32'hFFFF_FFFF;
  endfunction

  // order: dp_rd, dp_wr, tf_rd, tf_wr, st_rd, ctl_wr
  function automatic logic [5:0] exp_vec(input logic [11:0] a, input logic [2:0] sz,
                                         input logic rd, input logic wr);
    logic [7:0] s;
    logic w;
    s = a[11:4];
    w = wr && !rd;
    if (s == 8'h00)
      return {rd && sz_valid(sz), w && (sz == 3'd2 || sz == 3'd4), 4'b0};
    if (s >= 8'h01 && s <= 8'h07)
      return {2'b0, rd && sz == 3'd1, w && sz == 3'd1, 2'b0};
    if (s == 8'h08 || s == 8'h16)
      return {4'b0, rd && sz == 3'd1, w && sz == 3'd1};
    return 6'b0;
  endfunction

  function automatic string tag_of(input logic [11:0] a, input logic [2:0] sz, input logic rd);
    logic [7:0] s;
    s = a[11:4];
    if (!sz_valid(sz)) return "R2";
    if (s == 8'h00) return rd ? "R3" : "R4";
    if (s >= 8'h01 && s <= 8'h07) return "R5";
    if (s == 8'h08 || s == 8'h16) return "R6";
    if (s == 8'h20) return "R7";
    if (s == 8'h30) return rd ? "R8" : "R9";
    return "R2";
  endfunction

  task automatic access(input logic [11:0] a, input logic [2:0] sz,
                        input logic rd, input logic wr, input logic [31:0] wd);
    logic [31:0] er;
    logic [5:0]  ev;
    string       t;
    @(negedge clk);
    dp_val    = $urandom;
    bus_addr  = a;
    bus_size  = sz;
    bus_rd    = rd;
    bus_wr    = wr;
    bus_wdata = wd;
    er = exp_rd(a, sz);
    ev = exp_vec(a, sz, rd, wr);
    t  = tag_of(a, sz, rd);
    @(negedge clk);
    bus_rd = 1'b0;
    bus_wr = 1'b0;
    if (rd) chk(bus_rdata == er, t, bus_rdata, er);
    chk(cap_vec == ev, {t, " strobes R1"}, {26'h0, cap_vec}, {26'h0, ev});
    if (ev[5] || ev[4])
      chk(cap_wide == (sz == 3'd4), {t, " width"}, {31'h0, cap_wide}, {31'h0, sz == 3'd4});
    if (ev[4]) chk(cap_dpw == wd, "R4 data", cap_dpw, wd);
    if (ev[3] || ev[2]) chk(cap_idx == a[6:4], "R5 index", {29'h0, cap_idx}, {29'h0, a[6:4]});
    if (ev[2]) chk(cap_tfw == wd[7:0], "R5 data", {24'h0, cap_tfw}, {24'h0, wd[7:0]});
    if (ev[0]) chk(cap_ctl == wd[7:0], "R6 data", {24'h0, cap_ctl}, {24'h0, wd[7:0]});
    if (wr && !rd && sz == 3'd4) begin
      if (a[11:4] == 8'h20) tm_sh = wd;
      if (a[11:4] == 8'h30 && wd[31]) irq_sh[31] = 1'b0;
    end
  endtask

  task automatic set_lines(input logic dma, input logic disk);
    @(negedge clk);
    if (dma != irq_dma_in)   irq_sh[31] = dma;
    if (disk != irq_disk_in) irq_sh[30] = disk;
    irq_dma_in  = dma;
    irq_disk_in = disk;
    @(negedge clk);
    chk(irq_dma_out == dma && irq_disk_out == disk, "R10 passthrough",
        {30'h0, irq_dma_out, irq_disk_out}, {30'h0, dma, disk});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd1234));
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_wr = 0; bus_rd = 0; bus_size = 3'd4;
    irq_dma_in = 0; irq_disk_in = 0; dp_val = '0; tm_sh = '0; irq_sh = '0;
    repeat (3) @(negedge clk);
    chk(drv_rst == 1'b1, "R11 drv_rst in reset", {31'h0, drv_rst}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(drv_rst == 1'b0, "R11 drv_rst after release", {31'h0, drv_rst}, 32'h0);
    chk(bus_rdata == 32'h0, "R11 rdata reset", bus_rdata, 32'h0);
    access(12'h200, 3'd4, 1, 0, 0);   // R11 timing zero
    access(12'h300, 3'd4, 1, 0, 0);   // R11 irq zero

    // R1: low nibble ignored; R7 timing write/read
    access(12'h20C, 3'd4, 0, 1, 32'hCAFE_1234);
    access(12'h207, 3'd4, 1, 0, 0);
    access(12'h203, 3'd2, 0, 1, 32'h1111_1111);  // refused size, R7
    access(12'h200, 3'd2, 1, 0, 0);
    // R12: read data holds over idle cycles
    access(12'h200, 3'd4, 1, 0, 0);
    held = bus_rdata;
    repeat (3) @(negedge clk);
    chk(bus_rdata == held, "R12 hold", bus_rdata, held);
    // R13: simultaneous read and write on timing slot
    access(12'h200, 3'd4, 1, 1, 32'hDEAD_BEEF);
    access(12'h200, 3'd4, 1, 0, 0);
    // R3/R4 data port sizes, R6 both status slots
    access(12'h000, 3'd1, 1, 0, 0);
    access(12'h000, 3'd2, 1, 0, 0);
    access(12'h004, 3'd4, 1, 0, 0);
    access(12'h000, 3'd1, 0, 1, 32'h0000_00AB);
    access(12'h000, 3'd2, 0, 1, 32'h0000_BEEF);
    access(12'h000, 3'd4, 0, 1, 32'h1234_5678);
    access(12'h080, 3'd1, 1, 0, 0);
    access(12'h160, 3'd1, 0, 1, 32'h0000_0004);
    access(12'h160, 3'd4, 1, 0, 0);
    access(12'hFF0, 3'd4, 1, 0, 0);

    // R8/R9 interrupt state
    set_lines(1, 0);
    access(12'h300, 3'd4, 1, 0, 0);
    set_lines(1, 1);
    access(12'h300, 3'd4, 1, 0, 0);
    access(12'h300, 3'd4, 0, 1, 32'h7FFF_FFFF);  // R9 no bit31: no effect
    access(12'h300, 3'd4, 1, 0, 0);
    access(12'h300, 3'd4, 0, 1, 32'h8000_0000);  // R9 clears bit31 with line high
    access(12'h300, 3'd4, 1, 0, 0);
    access(12'h300, 3'd2, 0, 1, 32'h8000_0000);  // refused size
    access(12'h300, 3'd4, 1, 0, 0);
    set_lines(0, 0);
    access(12'h300, 3'd4, 1, 0, 0);
    // R9 same-cycle: DMA line rises while software clears
    @(negedge clk);
    irq_dma_in = 1'b1;
    bus_addr = 12'h300; bus_size = 3'd4; bus_wr = 1'b1; bus_wdata = 32'h8000_0000;
    @(negedge clk);
    bus_wr = 1'b0;
    irq_sh[31] = 1'b1;
    access(12'h300, 3'd4, 1, 0, 0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0]  s;
      logic [2:0]  sz;
      logic        r;
      int          k;
      k = int'($urandom % 14);
      case (k)
        8:  s = 8'h08;
        9:  s = 8'h16;
        10: s = 8'h20;
        11: s = 8'h30;
        12, 13: s = 8'($urandom);
        default: s = 8'(k);
      endcase
      case ($urandom % 5)
        0: sz = 3'd1;
        1: sz = 3'd2;
        2: sz = 3'd4;
        3: sz = 3'd3;
        default: sz = 3'd0;
      endcase
      r = 1'($urandom);
      access({s, 4'($urandom)}, sz, r, !r, $urandom);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule